// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a table of saturating counters. Low bits of the branch address pick a row of the table. Within that row, a global outcome history picks one counter. The history is a shift register that records the directions of the most recent resolved branches, whatever their address.

The history length m and the counter width n are parameters. The same RTL therefore covers (1,1), (2,2) and (5,1) style buffers. The front end presents an address on the lookup port and receives a direction in the same cycle. When a branch resolves, the back end presents its address and outcome on the training port. The block then trains the selected counter and shifts the outcome into the history in the same clock edge.

Top module: `cbp_predictor`

## Requirements
- R1: `predTaken` is the most significant bit of the counter at row index {predAddr[ADDR_LSB +: IDX_W], history}, with the history in the low bits. It follows `predAddr` combinationally, in the same cycle.
- R2: A training write with `updTaken`=1 adds one to the selected counter, which stops at 2^n−1.
- R3: A training write with `updTaken`=0 subtracts one from the selected counter, which stops at 0.
- R4: A training write selects its counter using the history value from before that write. On the same edge, the history shifts left by one, and the new outcome (1 = taken) enters bit 0.
- R5: Every training write shifts the single global history, whatever its address. A write to one branch therefore changes which counter predicts another branch.
- R6: A synchronous reset clears the history to all not-taken and every counter to 0, so every lookup returns not-taken.
- R7: Address bits below ADDR_LSB and above the index field do not affect counter selection.
- R8: While `updValid` is low, neither the counters nor the history change, whatever `updAddr` and `updTaken` carry.
- R9: With m=5 and n=1, the following repeating pattern reaches zero mispredictions in steady state: a loop branch resolving taken four times and then not-taken, followed by one taken outer branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| predAddr | input | ADDR_W | Branch address to look up |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| updValid | input | 1 | Training write strobe |
| updAddr | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The (2,2) instance is trained with the following patterns:
- Long runs of taken outcomes on one address, which show saturation at the top of the counter.
- Runs of not-taken outcomes from reset, which show that the counter stops at the bottom rather than wrapping.
- Outcomes interleaved between two addresses, which separate pre-shift counter selection from post-shift selection and show that the history is shared.

Aliased addresses and idle cycles carrying a live outcome show which inputs must be ignored. A second instance, set up as (5,1), runs the nested-loop outcome pattern for several periods. It separates a predictor that correlates on enough history, and so reaches zero mispredictions, from one that keeps missing the loop exit.

// File: rtl/cbp_pkg.sv
`timescale 1ns/1ps
package cbp_pkg;

  // Strobes from the training control to the counter/history datapath
  typedef struct packed {
    logic wrEn;   // write the selected counter
    logic up;     // count toward taken
    logic down;   // count toward not-taken
    logic shift;  // shift the outcome into the global history
  } cbpStrobes_t;

endpackage

// File: rtl/cbp_ctrl.sv
`timescale 1ns/1ps
module cbp_ctrl
  import cbp_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             updValid,
  input  logic             updTaken,
  input  logic [CNT_W-1:0] selCnt,
  output cbpStrobes_t      strobes
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic atMax;
  logic atMin;

  assign atMax = (selCnt == CNT_MAX);
  assign atMin = (selCnt == CNT_MIN);

  always_comb begin
    strobes       = '0;
    strobes.shift = updValid;
    strobes.up    = updValid &&  updTaken && !atMax;
    strobes.down  = updValid && !updTaken && !atMin;
    strobes.wrEn  = strobes.up || strobes.down;
  end

endmodule

// File: rtl/cbp_datapath.sv
`timescale 1ns/1ps
module cbp_datapath
  import cbp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ADDR_LSB = 2,
  parameter int IDX_W    = 4,
  parameter int HIST_W   = 2,
  parameter int CNT_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] predAddr,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              updTaken,
  input  cbpStrobes_t       strobes,
  output logic              predTaken,
  output logic [CNT_W-1:0]  selCnt,
  output logic [HIST_W-1:0] globalHist
);

  localparam int ROW_W = IDX_W + HIST_W;
  localparam int DEPTH = 1 << ROW_W;

  logic [HIST_W-1:0] histQ;
  logic [CNT_W-1:0]  cntQ [DEPTH];
  logic [ROW_W-1:0]  predRow;
  logic [ROW_W-1:0]  updRow;
  logic [CNT_W-1:0]  cntNext;
  logic [CNT_W-1:0]  predCnt;

  // Row formation: address index bits above history bits, or history only
  generate
    if (IDX_W > 0) begin : g_addrIdx
      assign predRow = {predAddr[ADDR_LSB +: IDX_W], histQ};
      assign updRow  = {updAddr[ADDR_LSB +: IDX_W], histQ};
    end else begin : g_histOnly
      assign predRow = histQ;
      assign updRow  = histQ;
    end
  endgenerate

  logic unusedAddrBits;
  assign unusedAddrBits = ^{predAddr, updAddr};

  assign predCnt   = cntQ[predRow];
  assign predTaken = predCnt[CNT_W-1];
  assign selCnt    = cntQ[updRow];
  assign cntNext   = strobes.up ? selCnt + 1'b1 : selCnt - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cntQ[i] <= '0;
    end else if (strobes.wrEn) begin
      cntQ[updRow] <= cntNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                histQ <= '0;
    else if (strobes.shift) histQ <= HIST_W'({histQ, updTaken});
  end

  assign globalHist = histQ;

endmodule

// File: rtl/cbp_predictor.sv
`timescale 1ns/1ps
module cbp_predictor
  import cbp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ADDR_LSB = 2,
  parameter int IDX_W    = 4,
  parameter int HIST_W   = 2,
  parameter int CNT_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] predAddr,
  output logic              predTaken,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              updTaken
);

  cbpStrobes_t       strobes;
  logic [CNT_W-1:0]  selCnt;
  logic [HIST_W-1:0] globalHist;

  cbp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .selCnt   (selCnt),
    .strobes  (strobes)
  );

  cbp_datapath #(
    .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB), .IDX_W(IDX_W),
    .HIST_W(HIST_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .predAddr   (predAddr),
    .updAddr    (updAddr),
    .updTaken   (updTaken),
    .strobes    (strobes),
    .predTaken  (predTaken),
    .selCnt     (selCnt),
    .globalHist (globalHist)
  );

endmodule

// File: rtl/cbp_predictor_checker.sv
`timescale 1ns/1ps
module cbp_predictor_checker
  import cbp_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              updValid,
  input logic              updTaken,
  input logic [CNT_W-1:0]  selCnt,
  input logic [HIST_W-1:0] globalHist,
  input cbpStrobes_t       strobes
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  assert_hist_shift_R4: assert property (@(posedge clk) disable iff (rst)
    updValid |=> globalHist == HIST_W'({$past(globalHist), $past(updTaken)}));

  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !updValid |=> $stable(globalHist));

  assert_sat_top_R2: assert property (@(posedge clk) disable iff (rst)
    (updValid && updTaken && selCnt == CNT_TOP) |-> !strobes.wrEn);

  assert_sat_bottom_R3: assert property (@(posedge clk) disable iff (rst)
    (updValid && !updTaken && selCnt == '0) |-> !strobes.wrEn);

  assert_one_dir_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.up, strobes.down}));

  assert_idle_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    !updValid |-> !strobes.wrEn && !strobes.shift);

endmodule

bind cbp_predictor cbp_predictor_checker #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .updValid   (updValid),
  .updTaken   (updTaken),
  .selCnt     (selCnt),
  .globalHist (globalHist),
  .strobes    (strobes)
);

// File: tb/cbp_predictor_tb.sv
`timescale 1ns/1ps
module cbp_predictor_tb;

  localparam int AW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst;
  logic [AW-1:0] predAddr, updAddr;
  logic          predTaken, updValid, updTaken;
  logic [AW-1:0] lPredAddr, lUpdAddr;
  logic          lPredTaken, lUpdValid, lUpdTaken;

  cbp_predictor #(.ADDR_W(AW), .ADDR_LSB(2), .IDX_W(4), .HIST_W(2), .CNT_W(2)) u_dut (
    .clk(clk), .rst(rst), .predAddr(predAddr), .predTaken(predTaken),
    .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken));

  cbp_predictor #(.ADDR_W(AW), .ADDR_LSB(2), .IDX_W(4), .HIST_W(5), .CNT_W(1)) u_loop (
    .clk(clk), .rst(rst), .predAddr(lPredAddr), .predTaken(lPredTaken),
    .updValid(lUpdValid), .updAddr(lUpdAddr), .updTaken(lUpdTaken));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model of the (2,2) instance, built from the requirements
  int       mCnt [64];
  logic [1:0] mHist;

  localparam logic [AW-1:0] A = 16'h0010;
  localparam logic [AW-1:0] B = 16'h0024;

  function automatic int rowOf(logic [AW-1:0] a);
    return int'({a[5:2], mHist});
  endfunction

  task automatic check(bit got, bit exp, string req, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1; updValid = 1'b0; lUpdValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) mCnt[i] = 0;
    mHist = 2'b00;
  endtask

  task automatic train(logic [AW-1:0] a, bit t);
    int r;
    @(negedge clk);
    updValid = 1'b1; updAddr = a; updTaken = t;
    @(posedge clk);
    #1;
    updValid = 1'b0;
    r = rowOf(a);
    if (t && mCnt[r] < 3) mCnt[r]++;
    if (!t && mCnt[r] > 0) mCnt[r]--;
    mHist = {mHist[0], t};
  endtask

  task automatic look(logic [AW-1:0] a, bit exp, string req, string what);
    @(negedge clk);
    predAddr = a;
    #1;
    check(predTaken, exp, req, what);
    check(predTaken, mCnt[rowOf(a)] >= 2, req, {what, " (model)"});
  endtask

  task automatic testReset();
    applyReset();
    for (int i = 0; i < 16; i++)
      look(AW'(i * 4), 1'b0, "R6", "lookup after reset");
  endtask

  task automatic testSatUp();
    applyReset();
    repeat (6) train(A, 1'b1);
    train(A, 1'b0); train(A, 1'b1); train(A, 1'b1);
    look(A, 1'b1, "R2", "top counter at 2 after one decrement");
    train(A, 1'b0); train(A, 1'b1); train(A, 1'b1);
    look(A, 1'b0, "R2", "top counter at 1 proves stop at 3");
  endtask

  task automatic testSatDown();
    applyReset();
    repeat (3) train(A, 1'b0);
    look(A, 1'b0, "R3", "counter stays at 0 under not-taken");
    train(A, 1'b1); train(B, 1'b0); train(B, 1'b0);
    look(A, 1'b0, "R3", "single increment from 0 gives 1");
  endtask

  task automatic testHistOrder();
    applyReset();
    train(B, 1'b0); train(A, 1'b1); train(A, 1'b1);
    look(A, 1'b0, "R4", "history 11 counter untouched");
    train(B, 1'b0); train(B, 1'b0);
    look(A, 1'b0, "R4", "history 00 counter at 1");
    train(A, 1'b1); train(B, 1'b0); train(B, 1'b0);
    look(A, 1'b1, "R4", "pre-shift history selects counter");
  endtask

  task automatic testGlobal();
    // continues from testHistOrder: history 00, A row 00 counter = 2
    train(B, 1'b1);
    look(A, 1'b0, "R5", "other branch shifted shared history");
    train(B, 1'b0); train(B, 1'b0);
    look(A, 1'b1, "R5", "other branch restored history 00");
  endtask

  task automatic testAlias();
    look(A | 16'h0040, 1'b1, "R7", "upper address bit ignored");
    look(A | 16'h8000, 1'b1, "R7", "top address bit ignored");
    look(A | 16'h0003, 1'b1, "R7", "low byte offset ignored");
    look(A + 16'h0004, 1'b0, "R7", "next index is a distinct row");
  endtask

  task automatic testIdle();
    @(negedge clk);
    updValid = 1'b0; updAddr = A; updTaken = 1'b1;
    repeat (3) @(posedge clk);
    look(A, 1'b1, "R8", "idle taken outcome leaves history");
    @(negedge clk);
    updTaken = 1'b0;
    repeat (3) @(posedge clk);
    look(A, 1'b1, "R8", "idle not-taken outcome leaves counter");
  endtask

  task automatic testComb();
    @(negedge clk);
    predAddr = A;
    #1 check(predTaken, 1'b1, "R1", "same-cycle lookup trained row");
    predAddr = A + 16'h0004;
    #1 check(predTaken, 1'b0, "R1", "same-cycle lookup untrained row");
    predAddr = A;
    #1 check(predTaken, 1'b1, "R1", "same-cycle lookup back");
  endtask

  task automatic testLoop();
    int missEarly = 0;
    int missLate  = 0;
    bit outcome;
    applyReset();
    for (int p = 0; p < 12; p++) begin
      for (int s = 0; s < 6; s++) begin
        outcome = (s != 4);
        @(negedge clk);
        lPredAddr = (s == 5) ? 16'h0030 : 16'h0020;
        lUpdAddr  = lPredAddr;
        lUpdTaken = outcome;
        lUpdValid = 1'b1;
        #1;
        if (lPredTaken != outcome) begin
          if (p < 6) missEarly++;
          else       missLate++;
        end
        @(posedge clk);
        #1 lUpdValid = 1'b0;
      end
    end
    checks++;
    if (missLate != 0) begin
      fails++;
      $display("FAIL R9 steady-state mispredictions: actual %0d expected 0", missLate);
    end
    checks++;
    if (missEarly == 0) begin
      fails++;
      $display("FAIL R9 warm-up mispredictions: actual %0d expected >0", missEarly);
    end
  endtask

  initial begin
    rst = 1'b1; predAddr = '0; updAddr = '0; updValid = 1'b0; updTaken = 1'b0;
    lPredAddr = '0; lUpdAddr = '0; lUpdValid = 1'b0; lUpdTaken = 1'b0;
    testReset();
    testSatUp();
    testSatDown();
    testHistOrder();
    testGlobal();
    testAlias();
    testIdle();
    testComb();
    testLoop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule